// File: doc/BRIEF.md
# String Instruction Memory Sequencer

This block carries out the block-string instructions of a processor core as a multi-cycle walk over a byte-addressed memory port. The core hands it an operation code, an element size, a destination pointer, a second operand and an element count, and pulses `start`. The second operand is a source pointer for copy and compare operations, and a data value for fill and search operations. The sequencer then issues one memory access at a time and waits for `mem_ready` on each one. When the operation ends, it pulses `done` and presents the updated pointer, operand and count together with the zero and carry flags.

Seven operations share one datapath. Three are byte copies: forward, backward, and forward-until-zero. One is a fill with a 1, 2 or 4 byte element. Two are element searches, one that runs until a match and one that runs while elements match. The last is a byte compare of two strings. The operations differ in which pointers move, in the direction of movement, in the stop rule and in how the flags are formed. Memory is little-endian: a multi-byte element has its lowest byte at the pointer address, and the port carries read and write data right-justified.

Top module: `str_seq`

## Requirements
- R1: While reset is high, and on the cycle after it, `busy`, `done` and `mem_req` are low, and the pointer, count and flag outputs are zero.
- R2: Op code 0 copies forward. Each step reads one byte at the source pointer and writes it at the destination pointer, raises both pointers by 1 and lowers the count by 1. It stops when the count reaches zero. The size input is ignored for copy and compare op codes.
- R3: Op code 1 copies backward. It works like R2, except that both pointers fall by 1 on each step.
- R4: Op code 2 works like R2, but it also stops right after the step that copied a byte of value zero.
- R5: Op code 3 fills. Each step writes the low element-size bytes of the value operand, lowest byte at the destination pointer, then raises the destination by the element size and lowers the count by 1. It runs until the count is zero. Size codes 0, 1 and 2 select 1, 2 and 4 bytes, and code 3 acts as 4.
- R6: Op code 4 searches until equal. Each step reads a zero-extended little-endian element at the destination pointer, raises the pointer by the element size and lowers the count. It stops on the first element equal to the value, or when the count is zero. Zero flag = (element ≠ value) and carry = (element ≤ value, unsigned), both for the last element read.
- R7: Op code 5 searches while equal. It steps like R6 but stops on the first element that differs from the value, or when the count is zero. Zero flag = (remaining count ≠ 0) and carry = (last element ≤ value).
- R8: Op code 6 compares bytes. Each step reads byte a at the destination pointer and byte b at the source pointer, raises both pointers by 1 and lowers the count. It stops on a ≠ b, on a = 0, or when the count is zero. Zero flag = (a ≠ b) and carry = (a ≥ b) for the last pair.
- R9: A start with a count of zero, or with op code 7, makes no memory access, leaves the pointers, count and flags unchanged, and still produces a `done` pulse.
- R10: Each access holds `mem_req` until a cycle with `mem_ready` high. Nothing in the operand state moves while the access waits. Each element step costs exactly one accepted access per byte stream it touches.
- R11: A `start` pulse that arrives while `busy` is high has no effect on the running operation.
- R12: `done` is high for exactly one cycle, and `busy` falls after it. Copy and fill operations never alter the flags, and the flags never change while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_i | input | 3 | Operation code |
| esz_i | input | 2 | Element size code for fill and search |
| dst_i | input | AW | Initial destination pointer |
| src_i | input | 32 | Initial source pointer or data value |
| cnt_i | input | CW | Initial element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_o | output | AW | Current or final destination pointer |
| src_o | output | 32 | Current or final source pointer or value |
| cnt_o | output | CW | Current or final count |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The hardest states to reach are the stops that end an operation before the count runs out. Examples are a compare that halts on an equal zero byte, a while-equal search whose last element matches and ends with a zero remaining count, and a copy-until-zero that meets a zero on its final permitted byte. Each trial builds its memory image from a small alphabet of byte values (0 to 3), so zero bytes and matching elements occur often. Compare trials copy a chosen prefix of the first string into the second and then flip one byte. Search values are taken from the image at offsets of 0 and 2 elements. Every case runs with memory that answers at once and with memory that inserts wait cycles, and a stray `start` is driven into each busy period.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;

    localparam int STR_DW = 32;

    typedef enum logic [2:0] {
        OP_CPY_FWD = 3'd0,
        OP_CPY_BWD = 3'd1,
        OP_CPY_NUL = 3'd2,
        OP_FILL    = 3'd3,
        OP_SCAN_EQ = 3'd4,
        OP_SCAN_NE = 3'd5,
        OP_CMP     = 3'd6,
        OP_NONE    = 3'd7
    } str_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_WR,
        ST_FIN
    } str_state_e;

    // outcome of one element step
    typedef struct packed {
        logic stop;
        logic upd;
        logic z;
        logic c;
    } str_verdict_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [STR_DW-1:0] elem_mask(input logic [1:0] sz,
                                                    input logic [STR_DW-1:0] d);
        case (sz)
            2'd0:    return {24'd0, d[7:0]};
            2'd1:    return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic is_copy(input str_op_e op);
        return (op == OP_CPY_FWD) || (op == OP_CPY_BWD) || (op == OP_CPY_NUL);
    endfunction

    function automatic logic is_scan(input str_op_e op);
        return (op == OP_SCAN_EQ) || (op == OP_SCAN_NE);
    endfunction

    function automatic logic uses_size(input str_op_e op);
        return (op == OP_FILL) || is_scan(op);
    endfunction

endpackage

// File: rtl/str_seq_step.sv
module str_seq_step
    import str_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  str_op_e             op,
    input  logic [1:0]          esz,
    input  logic [AW-1:0]       dst,
    input  logic [STR_DW-1:0]   src,
    input  logic [CW-1:0]       cnt,
    output logic [AW-1:0]       dst_nx,
    output logic [STR_DW-1:0]   src_nx,
    output logic [CW-1:0]       cnt_nx
);

    logic [AW-1:0] stride;

    always_comb begin
        stride = AW'(elem_bytes(esz));
        dst_nx = dst;
        src_nx = src;
        case (op)
            OP_CPY_BWD: begin
                dst_nx = dst - AW'(1);
                src_nx = src - 32'd1;
            end
            OP_CPY_FWD, OP_CPY_NUL, OP_CMP: begin
                dst_nx = dst + AW'(1);
                src_nx = src + 32'd1;
            end
            OP_FILL, OP_SCAN_EQ, OP_SCAN_NE: begin
                dst_nx = dst + stride;
            end
            default: begin
                dst_nx = dst;
            end
        endcase
    end

    assign cnt_nx = cnt - CW'(1);

endmodule

// File: rtl/str_seq_eval.sv
module str_seq_eval
    import str_seq_pkg::*;
#(
    parameter int CW = 32
) (
    input  str_op_e             op,
    input  logic [STR_DW-1:0]   elem_a,
    input  logic [STR_DW-1:0]   elem_b,
    input  logic [STR_DW-1:0]   val,
    input  logic [CW-1:0]       cnt_nx,
    output str_verdict_t        vd
);

    logic last;

    always_comb begin
        last = (cnt_nx == '0);
        vd   = '0;
        case (op)
            OP_CPY_FWD, OP_CPY_BWD, OP_FILL: begin
                vd.stop = last;
            end
            OP_CPY_NUL: begin
                vd.stop = last || (elem_a[7:0] == 8'd0);
            end
            OP_SCAN_EQ: begin
                vd.stop = last || (elem_a == val);
                vd.upd  = 1'b1;
                vd.z    = (elem_a != val);
                vd.c    = (elem_a <= val);
            end
            OP_SCAN_NE: begin
                vd.stop = last || (elem_a != val);
                vd.upd  = 1'b1;
                vd.z    = !last;
                vd.c    = (elem_a <= val);
            end
            OP_CMP: begin
                vd.stop = last || (elem_a != elem_b) || (elem_a[7:0] == 8'd0);
                vd.upd  = 1'b1;
                vd.z    = (elem_a != elem_b);
                vd.c    = (elem_a >= elem_b);
            end
            default: begin
                vd.stop = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/str_seq.sv
module str_seq
    import str_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          op_i,
    input  logic [1:0]          esz_i,
    input  logic [AW-1:0]       dst_i,
    input  logic [STR_DW-1:0]   src_i,
    input  logic [CW-1:0]       cnt_i,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       dst_o,
    output logic [STR_DW-1:0]   src_o,
    output logic [CW-1:0]       cnt_o,
    output logic                z_o,
    output logic                c_o,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [1:0]          mem_size,
    output logic [STR_DW-1:0]   mem_wdata,
    input  logic [STR_DW-1:0]   mem_rdata,
    input  logic                mem_ready
);

    str_state_e          state_q;
    str_op_e             op_q;
    str_op_e             op_in;
    logic [1:0]          esz_q;
    logic [AW-1:0]       dst_q, dst_nx;
    logic [STR_DW-1:0]   src_q, src_nx, tmp_q, rd_m, cur_a;
    logic [CW-1:0]       cnt_q, cnt_nx;
    logic                z_q, c_q;
    logic                adv;
    str_verdict_t        vd;

    assign op_in = str_op_e'(op_i);
    assign rd_m  = elem_mask(esz_q, mem_rdata);
    assign cur_a = (state_q == ST_RD1) ? rd_m : tmp_q;

    str_seq_step #(.AW(AW), .CW(CW)) u_step (
        .op     (op_q),
        .esz    (esz_q),
        .dst    (dst_q),
        .src    (src_q),
        .cnt    (cnt_q),
        .dst_nx (dst_nx),
        .src_nx (src_nx),
        .cnt_nx (cnt_nx)
    );

    str_seq_eval #(.CW(CW)) u_eval (
        .op     (op_q),
        .elem_a (cur_a),
        .elem_b (rd_m),
        .val    (src_q),
        .cnt_nx (cnt_nx),
        .vd     (vd)
    );

    // memory port drive
    always_comb begin
        mem_req   = (state_q == ST_RD1) || (state_q == ST_RD2) || (state_q == ST_WR);
        mem_we    = (state_q == ST_WR);
        mem_size  = esz_q;
        mem_wdata = elem_mask(esz_q, (op_q == OP_FILL) ? src_q : tmp_q);
        case (state_q)
            ST_RD1:  mem_addr = is_copy(op_q) ? src_q[AW-1:0] : dst_q;
            ST_RD2:  mem_addr = src_q[AW-1:0];
            default: mem_addr = dst_q;
        endcase
    end

    // a completed access that finishes one element step
    assign adv = mem_ready && (((state_q == ST_RD1) && is_scan(op_q)) ||
                               (state_q == ST_RD2) || (state_q == ST_WR));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            esz_q   <= 2'd0;
            dst_q   <= '0;
            src_q   <= '0;
            cnt_q   <= '0;
            tmp_q   <= '0;
            z_q     <= 1'b0;
            c_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= op_in;
                        esz_q <= uses_size(op_in) ? esz_i : 2'd0;
                        dst_q <= dst_i;
                        src_q <= src_i;
                        cnt_q <= cnt_i;
                        if ((cnt_i == '0) || (op_in == OP_NONE)) begin
                            state_q <= ST_FIN;
                        end else if (op_in == OP_FILL) begin
                            state_q <= ST_WR;
                        end else begin
                            state_q <= ST_RD1;
                        end
                    end
                end
                ST_RD1: begin
                    if (mem_ready) begin
                        tmp_q <= rd_m;
                        if (is_copy(op_q)) begin
                            state_q <= ST_WR;
                        end else if (op_q == OP_CMP) begin
                            state_q <= ST_RD2;
                        end
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= state_q;
                end
            endcase

            if (adv) begin
                dst_q <= dst_nx;
                src_q <= src_nx;
                cnt_q <= cnt_nx;
                if (vd.stop) begin
                    state_q <= ST_FIN;
                    if (vd.upd) begin
                        z_q <= vd.z;
                        c_q <= vd.c;
                    end
                end else if (op_q != OP_FILL) begin
                    state_q <= ST_RD1;
                end
            end
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_FIN);
    assign dst_o = dst_q;
    assign src_o = src_q;
    assign cnt_o = cnt_q;
    assign z_o   = z_q;
    assign c_o   = c_q;

endmodule

// File: rtl/str_seq_chk.sv
module str_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           done,
    input logic           mem_req,
    input logic           mem_ready,
    input logic [AW-1:0]  dst_o,
    input logic [31:0]    src_o,
    input logic [CW-1:0]  cnt_o,
    input logic           z_o,
    input logic           c_o
);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> ($stable(dst_o) && $stable(src_o) && $stable(cnt_o)));

    // R10
    req_in_op_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R11
    cnt_no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (cnt_o <= $past(cnt_o)));

    // R12
    idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(z_o) && $stable(c_o)));

endmodule

bind str_seq str_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .dst_o     (dst_o),
    .src_o     (src_o),
    .cnt_o     (cnt_o),
    .z_o       (z_o),
    .c_o       (c_o)
);

// File: tb/sim_str_seq.sv
`timescale 1ns/1ps
module sim_str_seq;

    localparam int AW = 8;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [1:0]  esz_i = 2'd0;
    logic [7:0]  dst_i = 8'd0;
    logic [31:0] src_i = 32'd0;
    logic [7:0]  cnt_i = 8'd0;
    logic        busy, done, z_o, c_o, mem_req, mem_we;
    logic [7:0]  dst_o, cnt_o, mem_addr;
    logic [31:0] src_o, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0;

    logic [7:0]  mem  [256];
    logic [7:0]  img  [256];
    logic [7:0]  rmem [256];
    logic        ld = 1'b0;
    logic        slow = 1'b0;
    logic        tog = 1'b0;
    int          acc_tot = 0;
    int          total = 0;
    int          bad = 0;
    bit          hung = 1'b0;

    logic [7:0]  e_dst, e_cnt;
    logic [31:0] e_src;
    logic        ez = 1'b0, ec = 1'b0;
    int          e_acc;

    always #2.5 clk = ~clk;

    str_seq #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_i(op_i), .esz_i(esz_i),
        .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .busy(busy), .done(done),
        .dst_o(dst_o), .src_o(src_o), .cnt_o(cnt_o), .z_o(z_o), .c_o(c_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // little-endian memory model
    always_comb mem_rdata = {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                             mem[8'(mem_addr + 1)], mem[mem_addr]};

    always @(posedge clk) begin
        if (mem_req && mem_ready) acc_tot <= acc_tot + 1;
        if (ld) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else if (mem_req && mem_we && mem_ready) begin
            mem[mem_addr] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem[8'(mem_addr + 1)] <= mem_wdata[15:8];
            if (mem_size[1]) begin
                mem[8'(mem_addr + 2)] <= mem_wdata[23:16];
                mem[8'(mem_addr + 3)] <= mem_wdata[31:24];
            end
        end
    end

    always @(negedge clk) begin
        tog       <= ~tog;
        mem_ready <= mem_req && (!slow || tog);
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rrd(input logic [7:0] a, input int nb);
        logic [31:0] r = 32'd0;
        for (int i = 0; i < nb; i++) r[8*i +: 8] = rmem[8'(a + i)];
        return r;
    endfunction

    // reference model built from the requirements
    task automatic ref_run(input int op, input int nb, input logic [7:0] d0,
                           input logic [31:0] s0, input logic [7:0] c0);
        logic [7:0]  d = d0;
        logic [31:0] s = s0;
        logic [7:0]  c = c0;
        logic [31:0] a, b;
        bit fin;
        e_acc = 0;
        fin = (c == 8'd0) || (op == 7);
        while (!fin) begin
            case (op)
                0, 1, 2: begin
                    a = {24'd0, rmem[s[7:0]]};
                    rmem[d] = a[7:0];
                    e_acc += 2;
                    if (op == 1) begin d = d - 8'd1; s = s - 32'd1; end
                    else begin d = d + 8'd1; s = s + 32'd1; end
                    c = c - 8'd1;
                    fin = (c == 8'd0) || (op == 2 && a[7:0] == 8'd0);
                end
                3: begin
                    for (int i = 0; i < nb; i++) rmem[8'(d + i)] = s[8*i +: 8];
                    e_acc += 1;
                    d = d + 8'(nb);
                    c = c - 8'd1;
                    fin = (c == 8'd0);
                end
                4, 5: begin
                    a = rrd(d, nb);
                    e_acc += 1;
                    d = d + 8'(nb);
                    c = c - 8'd1;
                    if (op == 4) begin
                        fin = (c == 8'd0) || (a == s);
                        if (fin) begin ez = (a != s); ec = (a <= s); end
                    end else begin
                        fin = (c == 8'd0) || (a != s);
                        if (fin) begin ez = (c != 8'd0); ec = (a <= s); end
                    end
                end
                default: begin
                    a = {24'd0, rmem[d]};
                    b = {24'd0, rmem[s[7:0]]};
                    e_acc += 2;
                    d = d + 8'd1;
                    s = s + 32'd1;
                    c = c - 8'd1;
                    fin = (c == 8'd0) || (a != b) || (a == 32'd0);
                    if (fin) begin ez = (a != b); ec = (a >= b); end
                end
            endcase
        end
        e_dst = d;
        e_src = s;
        e_cnt = c;
    endtask

    task automatic trial(input int op, input int sz, input int ci, input int v, input int seed);
        logic [7:0]  d0, c0;
        logic [31:0] s0;
        int nb, k, base, w, mism;
        bit noise;
        string tg, ftg;
        c0 = (ci == 0) ? 8'd0 : (ci == 1) ? 8'd1 : (ci == 2) ? 8'd3 : 8'd6;
        nb = (op >= 3 && op <= 5) ? ((sz == 0) ? 1 : (sz == 1) ? 2 : 4) : 1;
        d0 = (op == 1) ? 8'd120 : 8'd40;
        s0 = (op == 1) ? 32'd230 : 32'd150;
        for (int i = 0; i < 256; i++) img[i] = 8'(((i * 13) ^ (seed * 7) ^ (i >> 2)) & 3);
        if (op == 6) begin
            k = (v == 0) ? 1 : (v == 1) ? 3 : 8;
            if (v == 2) for (int i = 0; i < 8; i++) img[8'(40 + i)] = img[8'(40 + i)] | 8'h10;
            for (int i = 0; i < k; i++) img[8'(150 + i)] = img[8'(40 + i)];
            img[8'(150 + k)] = img[8'(40 + k)] ^ 8'h05;
        end
        if (op == 3) s0 = 32'hA5C3_1E70 + 32'(v);
        for (int i = 0; i < 256; i++) rmem[i] = img[i];
        if (op == 4 || op == 5)
            s0 = (v == 0) ? rrd(d0, nb) : (v == 1) ? rrd(8'(d0 + 2 * nb), nb) : 32'd3;
        ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
        ref_run(op, nb, d0, s0, c0);

        case (op)
            0: tg = "R2";
            1: tg = "R3";
            2: tg = "R4";
            3: tg = "R5";
            4: tg = "R6";
            5: tg = "R7";
            6: tg = "R8";
            default: tg = "R9";
        endcase
        if (c0 == 8'd0) tg = "R9";
        ftg = (tg == "R9") ? "R9" : (op <= 3) ? "R12" : tg;

        base = acc_tot;
        op_i = 3'(op); esz_i = 2'(sz); dst_i = d0; src_i = s0; cnt_i = c0; start = 1'b1;
        @(negedge clk);
        noise = (c0 != 8'd0) && (op != 7);
        if (noise) begin
            op_i = 3'd3; cnt_i = 8'd9; dst_i = 8'h00; src_i = 32'h55;
        end else begin
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 300) begin
            @(negedge clk);
            start = 1'b0;
            w++;
        end
        if (!done) begin
            chk(1'b0, tg, "watchdog", 32'(w), 32'd0);
            hung = 1'b1;
            return;
        end
        chk(dst_o == e_dst, tg, "dst", {24'd0, dst_o}, {24'd0, e_dst});
        chk(src_o == e_src, tg, "src", src_o, e_src);
        chk(cnt_o == e_cnt, tg, "cnt", {24'd0, cnt_o}, {24'd0, e_cnt});
        chk(z_o == ez, ftg, "zflag", {31'd0, z_o}, {31'd0, ez});
        chk(c_o == ec, ftg, "cflag", {31'd0, c_o}, {31'd0, ec});
        chk((acc_tot - base) == e_acc, slow ? "R10" : tg, "accesses",
            32'(acc_tot - base), 32'(e_acc));
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== rmem[i]) mism++;
        chk(mism == 0, tg, "memory", 32'(mism), 32'd0);
        if (noise)
            chk(dst_o == e_dst && cnt_o == e_cnt, "R11", "stray start",
                {24'd0, cnt_o}, {24'd0, e_cnt});
        @(negedge clk);
        chk(!done && !busy, "R12", "done pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        int seed = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "ctl", {29'd0, busy, done, mem_req}, 32'd0);
        chk(dst_o == 8'd0 && cnt_o == 8'd0 && src_o == 32'd0, "R1", "regs",
            {24'd0, cnt_o}, 32'd0);
        chk(!z_o && !c_o, "R1", "flags", {30'd0, z_o, c_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "post-reset", {29'd0, busy, done, mem_req}, 32'd0);
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int ci = 0; ci < 4; ci++)
                    for (int v = 0; v < 3; v++)
                        for (int sl = 0; sl < 2; sl++)
                            if (!hung) begin
                                slow = sl[0];
                                trial(op, sz, ci, v, seed);
                                seed++;
                            end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule